// File: doc/BRIEF.md
# Multi-phase switch gate controller

This block decides, clock by clock, which switches of a synchronous buck power stage may conduct. The stage is built from up to ten parallel power blocks, each with a high-side and a low-side switch. A single switching sequencer is shared by all blocks, and a 2-bit select code decides how many blocks follow it. Blocks that are not selected are parked with both enables low and a per-block high-impedance flag raised. Every sensed quantity arrives as a synchronous digital flag: the PWM request, a peak overcurrent, an inductor zero crossing, and a request from the error amplifier to sink current.

A switching cycle opens on a rising edge of the PWM request. The high-side switch then conducts for at least a minimum on-time, and the off-time between high-side pulses is also held to a minimum. Both limits are counted in system clocks. A single dead cycle separates every high-to-low and low-to-high change. A peak overcurrent cuts the high-side pulse in the same cycle and keeps it off until the next request edge.

With diode emulation active, the low-side switch opens once the inductor current reaches zero, which lets the current go discontinuous. A sink request from the error amplifier turns the low-side switch back on. The emulation input is taken only as the high-side pulse begins, while inductor current is building up, so a change never lands in the middle of a cycle.

Top module: `mphase_gate_ctl`

## Requirements
- R1: Select code `sel_i` enables a number of blocks starting from block 0: 2'b00 enables all ten, 2'b01 enables blocks 0 to 3, 2'b10 enables blocks 0 and 1, and 2'b11 enables none. A block that is not enabled has `hs_en_o` and `ls_en_o` low and `hiz_o` high. An enabled block has `hiz_o` low.
- R2: While `enable_i` is low, every `hs_en_o` and `ls_en_o` bit is low and every `hiz_o` bit is high, starting in the same cycle. After re-enable the sequencer starts in the low phase and counts its off-time from zero.
- R3: A rising edge of `pwm_req_i` starts a cycle. If the off-time is already met, the high-side enables of the enabled blocks rise two clocks after the edge, and the cycle between is a dead cycle.
- R4: A high-side pulse lasts at least MIN_ON clocks. A request that falls earlier stretches the pulse to exactly MIN_ON clocks, unless overcurrent or disable ends it.
- R5: Between two high-side pulses the high-side enable is low for at least MIN_OFF+1 clocks. A request that arrives earlier is held back to exactly that length.
- R6: If `oc_flag_i` is high during a high-side pulse, the high-side enables drop in that same cycle. They stay low until the next rising edge of `pwm_req_i`.
- R7: No block ever has high-side and low-side enabled together. A clock with either one on is always followed by a clock with the other one off.
- R8: With diode emulation off, the low-side enables of the enabled blocks are on for the whole low phase.
- R9: With diode emulation on, the low-side enables go low in the clock after `zc_flag_i` is seen in the low phase. They stay low for the rest of that low phase.
- R10: With diode emulation on and a zero crossing already seen, `sink_req_i` high turns the low-side enables on in the same cycle.
- R11: `de_en_i` takes effect only at the clock where the high-side pulse starts. A change during a low phase does not change that phase's low-side behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Converter enable; low parks every switch |
| pwm_req_i | input | 1 | PWM request level; its rising edge opens a cycle |
| sel_i | input | 2 | Block-count select code |
| de_en_i | input | 1 | Diode-emulation request |
| oc_flag_i | input | 1 | Peak overcurrent flag |
| zc_flag_i | input | 1 | Inductor current zero-crossing flag |
| sink_req_i | input | 1 | Error-amplifier request to sink current |
| hs_en_o | output | NBLK | High-side switch enables, one per block |
| ls_en_o | output | NBLK | Low-side switch enables, one per block |
| hiz_o | output | NBLK | Per-block high-impedance flag |

## Verification
The sequencer is driven with long PWM periods, which show the plain dead-cycle handoff. A request shorter than the on-time separates a stretched pulse from a truncated one. A low gap shorter than the off-time shows whether the next pulse is held back. A mid-pulse overcurrent tells a cut that holds apart from one released early by a request that stays high. Each select code is applied with the converter idle and while it switches, so the block mask is checked against the shared sequencer. Zero-crossing, sink and emulation-toggle pulses placed inside a low phase separate emulation taking effect at a pulse start from emulation leaking into a cycle already running.

// File: rtl/gate_ctl_pkg.sv
package gate_ctl_pkg;

  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_RISE = 2'd1,
    PH_HIGH = 2'd2,
    PH_FALL = 2'd3
  } phase_t;

  // number of blocks that follow the sequencer for a select code
  function automatic int unsigned blk_count(input logic [1:0] code,
                                            input int unsigned n_all,
                                            input int unsigned n_mid,
                                            input int unsigned n_low);
    case (code)
      2'b00:   return n_all;
      2'b01:   return n_mid;
      2'b10:   return n_low;
      default: return 0;
    endcase
  endfunction

  // counter width able to hold the larger of two limits plus headroom
  function automatic int unsigned cnt_width(input int unsigned a,
                                            input int unsigned b);
    return $clog2(((a > b) ? a : b) + 2);
  endfunction

endpackage

// File: rtl/gate_phase_fsm.sv
module gate_phase_fsm
  import gate_ctl_pkg::*;
#(
  parameter int unsigned MIN_ON  = 20,
  parameter int unsigned MIN_OFF = 13,
  parameter int unsigned CW      = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active,
  input  logic   pwm_req,
  input  logic   oc_flag,
  input  logic   zc_flag,
  input  logic   de_req,
  output phase_t phase,
  output logic   zc_seen,
  output logic   de_mode
);

  logic [CW-1:0] on_cnt, off_cnt;
  logic          pwm_q, oc_blk;
  logic          cycle_start, hs_want, off_done, hs_cut;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign cycle_start = pwm_req & ~pwm_q;
  assign hs_want     = pwm_req & (~oc_blk | cycle_start);
  assign off_done    = 32'(off_cnt) >= MIN_OFF;
  assign hs_cut      = oc_flag | (~pwm_req & (32'(on_cnt) >= MIN_ON));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_LOW;
      on_cnt  <= '0;
      off_cnt <= '0;
      oc_blk  <= 1'b0;
      zc_seen <= 1'b0;
      de_mode <= 1'b0;
      pwm_q   <= 1'b0;
    end else begin
      pwm_q <= pwm_req;
      if (!active) begin
        phase   <= PH_LOW;
        on_cnt  <= '0;
        off_cnt <= '0;
        oc_blk  <= 1'b0;
        zc_seen <= 1'b0;
        de_mode <= 1'b0;
      end else begin
        if (phase == PH_HIGH && oc_flag) oc_blk <= 1'b1;
        else if (cycle_start)            oc_blk <= 1'b0;
        unique case (phase)
          PH_LOW: begin
            off_cnt <= bump(off_cnt);
            if (zc_flag) zc_seen <= 1'b1;
            if (hs_want && off_done) phase <= PH_RISE;
          end
          PH_RISE: begin
            phase   <= PH_HIGH;
            on_cnt  <= CW'(1);
            de_mode <= de_req;
          end
          PH_HIGH: begin
            if (hs_cut) begin
              phase   <= PH_FALL;
              off_cnt <= CW'(1);
            end else begin
              on_cnt <= bump(on_cnt);
            end
          end
          PH_FALL: begin
            phase   <= PH_LOW;
            zc_seen <= 1'b0;
            off_cnt <= bump(off_cnt);
          end
        endcase
      end
    end
  end

  // R3
  rise_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RISE && active) |=> (phase == PH_HIGH));

  // R11
  de_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase != PH_RISE) |=> $stable(de_mode));

endmodule

// File: rtl/blk_mask.sv
module blk_mask
  import gate_ctl_pkg::*;
#(
  parameter int unsigned NBLK    = 10,
  parameter int unsigned CNT_ALL = 10,
  parameter int unsigned CNT_MID = 4,
  parameter int unsigned CNT_LOW = 2
) (
  input  logic [1:0]      sel_i,
  input  logic            active_i,
  input  logic            hs_core_i,
  input  logic            ls_core_i,
  output logic [NBLK-1:0] hs_o,
  output logic [NBLK-1:0] ls_o,
  output logic [NBLK-1:0] hiz_o
);

  int unsigned n_on;
  always_comb n_on = blk_count(sel_i, CNT_ALL, CNT_MID, CNT_LOW);

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam int unsigned IDX = g;
    logic live;
    assign live     = active_i & (IDX < n_on);
    assign hs_o[g]  = live & hs_core_i;
    assign ls_o[g]  = live & ls_core_i;
    assign hiz_o[g] = ~live;
  end

endmodule

// File: rtl/mphase_gate_ctl.sv
module mphase_gate_ctl
  import gate_ctl_pkg::*;
#(
  parameter int unsigned NBLK    = 10,
  parameter int unsigned CNT_MID = 4,
  parameter int unsigned CNT_LOW = 2,
  parameter int unsigned MIN_ON  = 20,
  parameter int unsigned MIN_OFF = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic            pwm_req_i,
  input  logic [1:0]      sel_i,
  input  logic            de_en_i,
  input  logic            oc_flag_i,
  input  logic            zc_flag_i,
  input  logic            sink_req_i,
  output logic [NBLK-1:0] hs_en_o,
  output logic [NBLK-1:0] ls_en_o,
  output logic [NBLK-1:0] hiz_o
);

  localparam int unsigned CW = cnt_width(MIN_ON, MIN_OFF);

  phase_t phase;
  logic   active, zc_seen, de_mode;
  logic   hs_core, ls_core, ls_block;

  assign active   = enable_i & (sel_i != 2'b11);
  assign ls_block = de_mode & zc_seen & ~sink_req_i;
  assign hs_core  = active & (phase == PH_HIGH) & ~oc_flag_i;
  assign ls_core  = active & (phase == PH_LOW) & ~ls_block;

  gate_phase_fsm #(
    .MIN_ON (MIN_ON),
    .MIN_OFF(MIN_OFF),
    .CW     (CW)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .pwm_req(pwm_req_i),
    .oc_flag(oc_flag_i),
    .zc_flag(zc_flag_i),
    .de_req (de_en_i),
    .phase  (phase),
    .zc_seen(zc_seen),
    .de_mode(de_mode)
  );

  blk_mask #(
    .NBLK   (NBLK),
    .CNT_ALL(NBLK),
    .CNT_MID(CNT_MID),
    .CNT_LOW(CNT_LOW)
  ) u_mask (
    .sel_i    (sel_i),
    .active_i (active),
    .hs_core_i(hs_core),
    .ls_core_i(ls_core),
    .hs_o     (hs_en_o),
    .ls_o     (ls_en_o),
    .hiz_o    (hiz_o)
  );

  // port-level run counters used only by the assertions below
  logic          hs_any, ls_any;
  logic [CW-1:0] hi_run_q, lo_run_q;
  assign hs_any = |hs_en_o;
  assign ls_any = |ls_en_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      hi_run_q <= hs_any ? ((&hi_run_q) ? hi_run_q : hi_run_q + 1'b1) : '0;
      lo_run_q <= hs_any ? '0 : ((&lo_run_q) ? lo_run_q : lo_run_q + 1'b1);
    end
  end

  // R7
  for (genvar g = 0; g < NBLK; g++) begin : g_chk
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en_o[g] && ls_en_o[g]));
    // R1
    parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_o[g] |-> (!hs_en_o[g] && !ls_en_o[g]));
  end

  // R7
  hs_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_any |=> !ls_any);

  // R7
  ls_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_any |=> !hs_any);

  // R6
  oc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag_i && phase == PH_HIGH) |=> !hs_any);

  // R4
  min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_any) && active && !oc_flag_i) |-> (32'(hi_run_q) >= MIN_ON));

  // R5
  min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_any) |-> (32'(lo_run_q) >= MIN_OFF));

  // R2
  off_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> (!hs_any && !ls_any && (&hiz_o)));

endmodule

// File: tb/mphase_gate_ctl_tb_top.sv
`timescale 1ns/1ps
module mphase_gate_ctl_tb_top;

  localparam int NB = 10;
  localparam int MIN_ON = 20;
  localparam int MIN_OFF = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, pwm = 0, de = 0, oc = 0, zc = 0, sink = 0;
  logic [1:0] sel = 2'b00;
  logic [NB-1:0] hs, ls, hz;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mphase_gate_ctl #(
    .NBLK(NB), .CNT_MID(4), .CNT_LOW(2), .MIN_ON(MIN_ON), .MIN_OFF(MIN_OFF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .pwm_req_i(pwm), .sel_i(sel),
    .de_en_i(de), .oc_flag_i(oc), .zc_flag_i(zc), .sink_req_i(sink),
    .hs_en_o(hs), .ls_en_o(ls), .hiz_o(hz)
  );

  // behavioural reference state
  int m_ph = 0;  // 0 low, 1 dead before high, 2 high, 3 dead after high
  int m_on = 0, m_off = 0;
  bit m_ocb = 0, m_zc = 0, m_de = 0, m_pq = 0;
  // port monitors
  bit prev_hs0 = 0;
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int n_sel(input logic [1:0] s);
    if (s == 2'b00) return 10;
    if (s == 2'b01) return 4;
    if (s == 2'b10) return 2;
    return 0;
  endfunction

  function automatic bit is_on();
    return en && sel != 2'b11;
  endfunction

  task automatic compare();
    logic [NB-1:0] e_hs, e_ls, e_hz;
    bit on, h, l;
    on = is_on();
    h = on && m_ph == 2 && !oc;
    l = on && m_ph == 0 && !(m_de && m_zc && !sink);
    for (int i = 0; i < NB; i++) begin
      bit live;
      live = on && (i < n_sel(sel));
      e_hs[i] = live && h;
      e_ls[i] = live && l;
      e_hz[i] = !live;
    end
    chk(hs === e_hs, "R3", "hs_en", hs, e_hs);
    chk(ls === e_ls, "R8", "ls_en", ls, e_ls);
    chk(hz === e_hz, "R1", "hiz", hz, e_hz);
    chk((hs & ls) == 0, "R7", "overlap", hs & ls, 0);
    if (prev_hs0) chk(ls[0] == 0, "R7", "dead after high", ls[0], 0);
    if (hs[0] && !prev_hs0) begin
      chk(lo_run >= MIN_OFF, "R5", "low run", lo_run, MIN_OFF);
      last_lo = lo_run;
    end
    if (!hs[0] && prev_hs0) begin
      last_hi = hi_run;
      if (on && !oc) chk(hi_run >= MIN_ON, "R4", "high run", hi_run, MIN_ON);
    end
    if (hs[0]) begin hi_run++; lo_run = 0; end
    else begin lo_run++; hi_run = 0; end
    prev_hs0 = hs[0];
  endtask

  task automatic mdl_update();
    bit start, want;
    if (!rst_n) begin
      m_ph = 0; m_on = 0; m_off = 0; m_ocb = 0; m_zc = 0; m_de = 0; m_pq = 0;
      return;
    end
    start = pwm && !m_pq;
    want = pwm && (!m_ocb || start);
    m_pq = pwm;
    if (!is_on()) begin
      m_ph = 0; m_on = 0; m_off = 0; m_ocb = 0; m_zc = 0; m_de = 0;
      return;
    end
    if (m_ph == 2 && oc) m_ocb = 1;
    else if (start) m_ocb = 0;
    case (m_ph)
      0: begin
        if (zc) m_zc = 1;
        if (want && m_off >= MIN_OFF) m_ph = 1;
        m_off++;
      end
      1: begin m_ph = 2; m_on = 1; m_de = de; end
      2: begin
        if (oc || (!pwm && m_on >= MIN_ON)) begin m_ph = 3; m_off = 1; end
        else m_on++;
      end
      default: begin m_ph = 0; m_zc = 0; m_off++; end
    endcase
  endtask

  task automatic step();
    #0.5;
    compare();
    @(posedge clk);
    mdl_update();
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic settle();
    #0.2;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    @(negedge clk);
    steps(4);
    rst_n = 1'b1;
    steps(3);
    settle();
    // R2 reset / disabled state
    chk(hs == 0, "R2", "hs while disabled", hs, 0);
    chk(ls == 0, "R2", "ls while disabled", ls, 0);
    chk(&hz, "R2", "hiz while disabled", hz, 10'h3ff);

    en = 1; sel = 2'b00;
    steps(20);
    settle();
    chk(ls == 10'h3ff, "R8", "low phase low-side", ls, 10'h3ff);
    pwm = 1;
    step(); settle();
    chk(hs == 0 && ls == 0, "R7", "dead cycle", {hs, ls}, 0);
    step(); settle();
    chk(hs == 10'h3ff, "R3", "high-side two clocks after edge", hs, 10'h3ff);
    steps(28); pwm = 0; steps(40);

    // R4 short request stretched
    pwm = 1; steps(4); pwm = 0; steps(40);
    chk(last_hi == MIN_ON, "R4", "stretched pulse length", last_hi, MIN_ON);

    // R5 short gap held back
    pwm = 1; steps(30); pwm = 0; steps(2); pwm = 1; steps(40);
    chk(last_lo == MIN_OFF + 1, "R5", "held gap length", last_lo, MIN_OFF + 1);
    pwm = 0; steps(40);

    // R6 overcurrent truncation
    pwm = 1; steps(10);
    oc = 1; settle();
    chk(hs == 0, "R6", "cut in same cycle", hs, 0);
    step(); oc = 0;
    for (int k = 0; k < 15; k++) begin
      settle();
      chk(hs == 0, "R6", "stays off while request high", hs, 0);
      step();
    end
    pwm = 0; steps(20);
    pwm = 1; steps(2); settle();
    chk(hs == 10'h3ff, "R6", "resumes on next edge", hs, 10'h3ff);
    steps(25); pwm = 0; steps(30);

    // R1 block selection
    sel = 2'b01; settle();
    chk(hz == 10'b1111110000, "R1", "hiz for four blocks", hz, 10'b1111110000);
    step(); pwm = 1; steps(25); settle();
    chk(hs == 10'b0000001111, "R1", "four blocks switch", hs, 10'b0000001111);
    pwm = 0; steps(30);
    sel = 2'b10; settle();
    chk(hz == 10'b1111111100, "R1", "hiz for two blocks", hz, 10'b1111111100);
    chk(ls == 10'b0000000011, "R1", "two blocks low-side", ls, 10'b0000000011);
    step();
    sel = 2'b11; settle();
    chk(&hz && hs == 0 && ls == 0, "R1", "all parked", hz, 10'h3ff);
    steps(5); sel = 2'b00; steps(20);

    // R9 / R10 / R11 diode emulation
    de = 1; pwm = 1; steps(25); pwm = 0; steps(5); settle();
    chk(ls == 10'h3ff, "R9", "low-side before zero cross", ls, 10'h3ff);
    zc = 1; step(); zc = 0; settle();
    chk(ls == 0, "R9", "low-side off after zero cross", ls, 0);
    steps(3); sink = 1; settle();
    chk(ls == 10'h3ff, "R10", "sink request turns low-side on", ls, 10'h3ff);
    step(); sink = 0; settle();
    chk(ls == 0, "R10", "released sink", ls, 0);
    de = 0; steps(3); settle();
    chk(ls == 0, "R11", "mode change mid low phase ignored", ls, 0);
    pwm = 1; steps(25); pwm = 0; steps(5);
    zc = 1; step(); zc = 0; settle();
    chk(ls == 10'h3ff, "R11", "emulation off after pulse start", ls, 10'h3ff);
    de = 1; step(); zc = 1; step(); zc = 0; settle();
    chk(ls == 10'h3ff, "R11", "late emulation request ignored", ls, 10'h3ff);
    steps(20);

    // R2 disable during a pulse
    pwm = 1; steps(8);
    en = 0; settle();
    chk(hs == 0 && ls == 0, "R2", "disable mid pulse", {hs, ls}, 0);
    chk(&hz, "R2", "hiz on disable", hz, 10'h3ff);
    steps(5); en = 1; settle();
    chk(ls == 10'h3ff, "R2", "restart in low phase", ls, 10'h3ff);
    steps(30); pwm = 0; steps(30);

    finish_run();
  end

endmodule